// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flagged Character Queue

This block turns an asynchronous serial line into characters. A one-cycle enable at sixteen times the bit rate paces it. The line first passes a short synchronizer. A falling edge starts a frame, and the block samples every following bit near its centre. It checks parity and the stop bit and recognises a held-low line as a break. Each finished character is stored with three flags: parity error, framing error and break.

Storage works in one of two modes. In the first mode it is a single holding register. In the second mode it is a queue of up to sixteen entries. In queue mode the block adds a fill threshold indication, a character timeout and a fixed commit delay. A host reads the head entry from the output pins and pops it with a one-cycle strobe. A DMA engine watches the receive-ready output.

Top module: `serial_rx_queue`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fill` is 0 and `data_avail`, `overrun`, `trig_hit`, `timeout` and `rx_ready` are all low.
- R2: Data bits arrive least significant bit first. `char_len` sets the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The stored byte is zero-extended in the unused high bits.
- R3: When `par_en` is 1, one parity bit follows the data. The expected parity is even when `par_odd` is 0 and odd when it is 1. A mismatch sets `rd_perr` for that entry. When `par_en` is 0, no parity bit is expected and `rd_perr` stays 0.
- R4: A stop bit sampled low sets `rd_ferr` for that entry. The data bits are still stored.
- R5: A break is a frame in which the data bits, the parity bit (if enabled) and the stop bit are all low. A break stores exactly one entry, with data 0, `rd_brk`=1, `rd_ferr`=1 and `rd_perr`=0. The block then waits for the line to return high before it looks for a new start bit.
- R6: A start bit that has gone high again by its mid-point sample is discarded. No entry is stored, and the block goes back to hunting for a start bit.
- R7: With `fifo_en`=0 the storage holds one character. `data_avail` and `rx_ready` rise within two clock cycles of the stop-bit sample.
- R8: With `fifo_en`=1 the storage holds 16 characters and hands them out in arrival order. Each character is committed 3 sample-enable periods after its stop-bit sample. Changing `fifo_en` empties the storage.
- R9: If a character completes while the storage is full, that character is dropped and the stored entries are kept. `overrun` is then set, and it stays set until the next `rd_pop`.
- R10: In queue mode `trig_hit` is high when `fill` is at or above the threshold chosen by `trig_sel`: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. In register mode `trig_hit` is always low.
- R11: In queue mode `timeout` rises when the queue is non-empty and, for four character times plus 8 sample-enable periods, no character has been committed and no pop has occurred. A pop clears it.
- R12: `rx_ready` follows `data_avail` in register mode. In queue mode it is high when `trig_hit` or `timeout` is high.
- R13: `rd_pop` while the storage is empty has no effect: `fill` stays 0 and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| char_len | input | 2 | Character length code (5 to 8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| trig_sel | input | 2 | Fill threshold select |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| fill | output | 5 | Number of stored entries |
| data_avail | output | 1 | Storage non-empty |
| overrun | output | 1 | A character was dropped |
| trig_hit | output | 1 | Fill threshold reached |
| timeout | output | 1 | Character timeout |
| rx_ready | output | 1 | DMA receive request |

## Verification
The assertions check the following on every cycle:
- `fill` never goes past the capacity of the selected mode.
- A break entry always carries zero data and a framing error.
- `overrun` rises only when the storage was full.
- `timeout` and `trig_hit` never appear without stored data or outside queue mode.
- A pop on empty storage cannot underflow `fill`.

The following depend on the serial waveform itself, so only the bench scenarios can show them:
- bit order and length decoding;
- parity polarity;
- rejection of short start pulses;
- the three-period commit delay against the immediate single-register path;
- the exact length of the timeout window.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [RXQ_DW-1:0] data;
  } rxq_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKWAIT
  } rxq_state_t;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rxq_deser.sv
module rxq_deser
  import rxq_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output rxq_entry_t ent
);
  localparam int CTW = $clog2(OVS);
  localparam logic [CTW-1:0] MID  = CTW'(OVS/2 - 1);
  localparam logic [CTW-1:0] LAST = CTW'(OVS - 1);

  rxq_state_t        state;
  logic [CTW-1:0]    cnt;
  logic [2:0]        bitn;
  logic [RXQ_DW-1:0] sh;
  logic              pbit;
  logic [2:0]        last_idx;
  logic [2:0]        shamt;
  logic [RXQ_DW-1:0] aligned;
  logic              is_brk;

  always_comb begin
    last_idx = 3'(4 + char_len);
    shamt    = 3'(3 - char_len);
    aligned  = sh >> shamt;
    is_brk   = (aligned == '0) && !(par_en && pbit) && !rxd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      done  <= 1'b0;
      ent   <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: if (!rxd) begin
            state <= S_START;
            cnt   <= '0;
          end
          S_START: if (cnt == MID) begin
            cnt <= '0;
            if (rxd) state <= S_IDLE;
            else begin
              state <= S_DATA;
              bitn  <= '0;
              sh    <= '0;
            end
          end else cnt <= cnt + 1'b1;
          S_DATA: if (cnt == LAST) begin
            cnt <= '0;
            sh  <= {rxd, sh[RXQ_DW-1:1]};
            if (bitn == last_idx) state <= par_en ? S_PAR : S_STOP;
            else                  bitn  <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (cnt == LAST) begin
            cnt   <= '0;
            pbit  <= rxd;
            state <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (cnt == LAST) begin
            cnt      <= '0;
            done     <= 1'b1;
            ent.data <= aligned;
            ent.brk  <= is_brk;
            ent.ferr <= !rxd;
            ent.perr <= par_en && !is_brk && ((^aligned ^ pbit) != par_odd);
            state    <= is_brk ? S_BRKWAIT : S_IDLE;
          end else cnt <= cnt + 1'b1;
          S_BRKWAIT: if (rxd) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       cap_one,
  input  logic                       wr_en,
  input  rxq_entry_t                 wr_data,
  input  logic                       pop,
  output rxq_entry_t                 head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  rxq_entry_t mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic full, do_pop, do_wr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full   = cap_one ? (count != '0) : (count == CW'(DEPTH));
    do_pop = pop && (count != '0) && !flush;
    do_wr  = wr_en && !flush && (!full || do_pop);
    drop   = wr_en && !flush && full && !do_pop;
    head   = mem[rp];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr)  wp <= nxt(wp);
      if (do_pop) rp <= nxt(rp);
      case ({do_wr, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int OVS          = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int COMMIT_DELAY = 3,
  parameter int TO_CHARS     = 4,
  parameter int TO_EXTRA     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick16,
  input  logic                       rx_in,
  input  logic                       fifo_en,
  input  logic [1:0]                 char_len,
  input  logic                       par_en,
  input  logic                       par_odd,
  input  logic [1:0]                 trig_sel,
  input  logic                       rd_pop,
  output logic [7:0]                 rd_data,
  output logic                       rd_perr,
  output logic                       rd_ferr,
  output logic                       rd_brk,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       data_avail,
  output logic                       overrun,
  output logic                       trig_hit,
  output logic                       timeout,
  output logic                       rx_ready
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = $clog2(COMMIT_DELAY) + 1;
  localparam int TW = $clog2(TO_CHARS*OVS*12 + TO_EXTRA + 1);

  logic       rxd, done, wr_en, drop, mode_q, flush;
  rxq_entry_t ent, pend_ent, head, wr_data;
  logic       pend_v;
  logic [PW-1:0] pend_cnt;
  logic [CW-1:0] count, lvl;
  logic [TW-1:0] tcnt, to_limit;
  logic [3:0]    frame_bits;
  logic          pend_fire, to_cond, lvl_cond;

  rxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_in), .dout(rxd)
  );

  rxq_deser #(.OVS(OVS)) u_deser (
    .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
    .done(done), .ent(ent)
  );

  // Mode change detection and queue-mode commit delay stage
  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= fifo_en;
  end
  assign flush = (fifo_en != mode_q);

  assign pend_fire = pend_v && tick16 && (pend_cnt == PW'(COMMIT_DELAY-1));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend_v   <= 1'b0;
      pend_cnt <= '0;
      pend_ent <= '0;
    end else if (done && fifo_en) begin
      pend_v   <= 1'b1;
      pend_cnt <= '0;
      pend_ent <= ent;
    end else if (pend_fire) begin
      pend_v <= 1'b0;
    end else if (pend_v && tick16) begin
      pend_cnt <= pend_cnt + 1'b1;
    end
  end

  always_comb begin
    wr_en   = fifo_en ? pend_fire : done;
    wr_data = fifo_en ? pend_ent  : ent;
  end

  rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .cap_one(!fifo_en),
    .wr_en(wr_en), .wr_data(wr_data), .pop(rd_pop),
    .head(head), .count(count), .drop(drop)
  );

  // Threshold and timeout window
  always_comb begin
    case (trig_sel)
      2'd0:    lvl = CW'(1);
      2'd1:    lvl = CW'(DEPTH/4);
      2'd2:    lvl = CW'(DEPTH/2);
      default: lvl = CW'(DEPTH-2);
    endcase
    frame_bits = 4'(7) + 4'(char_len) + 4'(par_en);
    to_limit   = TW'(TO_CHARS*OVS) * TW'(frame_bits) + TW'(TO_EXTRA);
    to_cond    = fifo_en && (count != '0) && (tcnt >= to_limit);
    lvl_cond   = fifo_en && (count >= lvl);
  end

  always_ff @(posedge clk) begin
    if (rst || wr_en || rd_pop || (count == '0) || !fifo_en) tcnt <= '0;
    else if (tick16 && (tcnt < to_limit))                    tcnt <= tcnt + 1'b1;
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      rd_perr    <= 1'b0;
      rd_ferr    <= 1'b0;
      rd_brk     <= 1'b0;
      data_avail <= 1'b0;
      overrun    <= 1'b0;
      trig_hit   <= 1'b0;
      timeout    <= 1'b0;
      rx_ready   <= 1'b0;
    end else begin
      rd_data    <= head.data;
      rd_perr    <= head.perr;
      rd_ferr    <= head.ferr;
      rd_brk     <= head.brk;
      data_avail <= (count != '0);
      trig_hit   <= lvl_cond;
      timeout    <= to_cond;
      rx_ready   <= fifo_en ? (lvl_cond || to_cond) : (count != '0);
      if (drop)        overrun <= 1'b1;
      else if (rd_pop) overrun <= 1'b0;
    end
  end

  assign fill = count;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          rd_pop,
  input logic [7:0]    rd_data,
  input logic          rd_perr,
  input logic          rd_ferr,
  input logic          rd_brk,
  input logic [CW-1:0] fill,
  input logic          data_avail,
  input logic          overrun,
  input logic          trig_hit,
  input logic          timeout
);
  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH)); // R8
  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && $stable(fifo_en)) |-> (fill <= CW'(1))); // R7
  AST_AVAIL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(data_avail) |-> ($past(fill) != '0)); // R7
  AST_BRK_SHAPE: assert property (@(posedge clk) disable iff (rst)
    rd_brk |-> (rd_data == 8'h00 && rd_ferr && !rd_perr)); // R5
  AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> ($past(fill) == ($past(fifo_en) ? CW'(DEPTH) : CW'(1)))); // R9
  AST_TIMEOUT_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    timeout |-> ($past(fill) != '0)); // R11
  AST_TRIG_QUEUE_ONLY: assert property (@(posedge clk) disable iff (rst)
    trig_hit |-> ($past(fifo_en) && $past(fill) != '0)); // R10
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && fill == '0) |=> (fill <= CW'(1))); // R13
endmodule

bind serial_rx_queue rxq_checker #(.DEPTH(DEPTH), .CW($clog2(DEPTH+1))) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .rd_pop(rd_pop),
  .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
  .fill(fill), .data_avail(data_avail), .overrun(overrun),
  .trig_hit(trig_hit), .timeout(timeout)
);

// File: tb/serial_rx_queue_test.sv
module serial_rx_queue_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic rx_in = 1'b1;
  logic fifo_en = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk;
  logic [4:0] fill;
  logic data_avail, overrun, trig_hit, timeout, rx_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd2);
  end

  serial_rx_queue uut (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in), .fifo_en(fifo_en),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .trig_sel(trig_sel),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rd_brk(rd_brk), .fill(fill), .data_avail(data_avail), .overrun(overrun),
    .trig_hit(trig_hit), .timeout(timeout), .rx_ready(rx_ready)
  );

  // {len[1:0], par_en, par_odd, bad_par, stop, data[7:0], exp_data[7:0], exp_perr, exp_ferr}
  localparam logic [23:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3F, 8'h1F, 1'b0, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h2A, 8'h2A, 1'b1, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 8'h55, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80, 8'h80, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 8'h01, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  // Sends start, data, optional parity, then the stop level.
  // stop_ticks: how long the stop level is held before returning.
  task automatic send_frame(input logic [7:0] d, input logic bad_par,
                            input logic stop_v, input int stop_ticks);
    int nb;
    logic p;
    nb = 5 + int'(char_len);
    p  = par_odd ^ bad_par;
    rx_in = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < nb; i++) begin
      rx_in = d[i];
      p = p ^ d[i];
      wait_ticks(16);
    end
    if (par_en) begin
      rx_in = p;
      wait_ticks(16);
    end
    rx_in = stop_v;
    wait_ticks(stop_ticks);
    if (stop_ticks >= 16) rx_in = 1'b1;
  endtask

  task automatic pop_one();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 fill", fill, 0);
    check("R1 avail", data_avail, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 flags", {overrun, trig_hit, timeout, rx_ready}, 0);

    // Table walk, single-register mode: R2 R3 R4 R7 R12
    foreach (VEC[k]) begin
      char_len = VEC[k][23:22];
      par_en   = VEC[k][21];
      par_odd  = VEC[k][20];
      wait_ticks(4);
      send_frame(VEC[k][17:10], VEC[k][19], VEC[k][18], 16);
      wait_ticks(4);
      check("R7 avail", data_avail, 1);
      check("R12 ready single", rx_ready, 1);
      check("R2 data", rd_data, VEC[k][9:2]);
      check("R3 perr", rd_perr, VEC[k][1]);
      check("R4 ferr", rd_ferr, VEC[k][0]);
      pop_one();
      check("R7 empty after pop", data_avail, 0);
    end

    char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;
    wait_ticks(4);
    // R7 immediate status in single mode
    send_frame(8'h5A, 1'b0, 1'b1, 10);
    check("R7 early avail", data_avail, 1);
    wait_ticks(6);
    pop_one();

    // R8 delayed commit in queue mode
    fifo_en = 1'b1;
    wait_ticks(4);
    send_frame(8'hC3, 1'b0, 1'b1, 10);
    check("R8 not yet committed", fill, 0);
    check("R8 avail delayed", data_avail, 0);
    wait_ticks(6);
    check("R8 committed", data_avail, 1);
    check("R8 data", rd_data, 8'hC3);
    pop_one();

    // R6 false start
    rx_in = 1'b0;
    wait_ticks(4);
    rx_in = 1'b1;
    wait_ticks(40);
    check("R6 no entry", fill, 0);
    send_frame(8'h96, 1'b0, 1'b1, 16);
    wait_ticks(4);
    check("R6 recovers", rd_data, 8'h96);
    pop_one();

    // R5 break
    rx_in = 1'b0;
    wait_ticks(200);
    rx_in = 1'b1;
    wait_ticks(20);
    check("R5 one entry", fill, 1);
    check("R5 brk", rd_brk, 1);
    check("R5 ferr", rd_ferr, 1);
    check("R5 data", rd_data, 0);
    pop_one();
    check("R5 drained", fill, 0);

    // R10 trigger, R9 overrun, R8 order
    trig_sel = 2'd2;
    for (int i = 0; i < 7; i++) send_frame(8'(8'h10 + i), 1'b0, 1'b1, 16);
    wait_ticks(4);
    check("R10 below level", trig_hit, 0);
    check("R12 ready below level", rx_ready, 0);
    send_frame(8'h17, 1'b0, 1'b1, 16);
    wait_ticks(4);
    check("R10 at level", trig_hit, 1);
    check("R12 ready at level", rx_ready, 1);
    for (int i = 8; i < 16; i++) send_frame(8'(8'h10 + i), 1'b0, 1'b1, 16);
    wait_ticks(4);
    check("R8 full", fill, 16);
    check("R9 no overrun yet", overrun, 0);
    send_frame(8'hEE, 1'b0, 1'b1, 16);
    wait_ticks(4);
    check("R9 overrun", overrun, 1);
    check("R9 fill kept", fill, 16);
    for (int i = 0; i < 16; i++) begin
      check("R8 order", rd_data, 8'h10 + i);
      pop_one();
      if (i == 0) check("R9 cleared by pop", overrun, 0);
    end
    check("R9 dropped char absent", fill, 0);

    // R11 timeout (8 bits, no parity: 4*160+8 = 648 periods)
    trig_sel = 2'd3;
    send_frame(8'h42, 1'b0, 1'b1, 16);
    wait_ticks(4);
    check("R11 no timeout early", timeout, 0);
    wait_ticks(600);
    check("R11 no timeout before window", timeout, 0);
    wait_ticks(60);
    check("R11 timeout", timeout, 1);
    check("R12 ready on timeout", rx_ready, 1);

    // R8 mode change empties storage
    fifo_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 flush on mode change", fill, 0);
    check("R11 timeout gone", timeout, 0);

    // R13 pop on empty
    pop_one();
    check("R13 fill", fill, 0);
    check("R13 flags", {data_avail, overrun}, 0);

    // R1 reset clears stored data
    send_frame(8'h33, 1'b0, 1'b1, 16);
    wait_ticks(4);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset empties", fill, 0);
    check("R1 reset avail", data_avail, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule